// File: doc/BRIEF.md
# Message-Passing DMA Engine

This block sits inside a processing element's network interface and moves whole messages between the local memory of one node and the local memory of another. Software programs a local source word address, a destination node number and a word count through a small register window. A write to the control register then starts a burst. The engine fetches the words from local memory and streams them onto the network as a single burst. The burst carries the destination node alongside the data and marks its final word.

On the receiving side, software announces where the next message should land by writing a receive address. If that announcement is already in place when a message arrives, the words go straight into local memory at consecutive addresses. If no announcement has been made, the engine parks the message in a one-message staging buffer. Once a receive address is written, it copies the parked words out one word per cycle. A completion flag tells software that delivery has finished.

Both network streams use valid/ready handshakes. A word moves on a rising edge where valid and ready are both high. A sender that raises valid must hold valid and its data steady until ready is seen. The engine lowers its receive ready while the staging buffer is occupied and no receive address has been announced, and while it picks the mode for a new message. The local memory read port returns data one cycle after a read enable. The memory write port accepts a write on every cycle.

Top module: `msg_dma_engine`

## Requirements
- R1: Register window by byte offset on `cfg_addr`: 0x00 source word address, 0x04 destination node, 0x08 word count (5 bits), 0x0C control, 0x10 receive address, 0x14 receive status. Reading 0x00, 0x04 or 0x08 returns the last value written there. Reading control gives busy in bit 1. Receive status gives posted in bit 0, done in bit 1 and staged in bit 2. After reset every readable bit is 0.
- R2: Writing control with bit 0 set, while idle and with a valid count N, sends exactly N words on the transmit stream. The words are memory contents from the source address upward, in address order. `tx_dest` equals the programmed node, and `tx_last` is high only on the Nth word.
- R3: Busy reads 1 from the cycle after an accepted start until the final transmit word has been accepted. A start written while busy is ignored.
- R4: A start with a count of 0 or above 16 is ignored: no memory read and no transmit word follow, and busy stays 0.
- R5: Register writes that are not an accepted start produce no memory read and no transmit traffic.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_last` and `tx_dest` stay unchanged.
- R7: A message that arrives while a receive is posted is written to the posted address plus word index. After its last word, posted clears and done sets.
- R8: A message that arrives while nothing is posted is staged, and staged reads 1. After a receive is posted, the words are written to the posted address one per cycle. Done reads 1 exactly N+1 cycles after the posting write, where N is the word count.
- R9: While a message is staged and no receive is posted, `rx_ready` stays low and the next message waits.
- R10: Writing the receive address while a receive is already posted has no effect: the earlier address is used.
- R11: The memory write port is used only while a receive is posted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| mem_rd_en | output | 1 | Local memory read enable |
| mem_rd_addr | output | 32 | Local memory read word address |
| mem_rd_data | input | 32 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | Local memory write enable |
| mem_wr_addr | output | 32 | Local memory write word address |
| mem_wr_data | output | 32 | Local memory write data |
| tx_valid | output | 1 | Transmit word valid |
| tx_ready | input | 1 | Network accepts transmit word |
| tx_data | output | 32 | Transmit word |
| tx_last | output | 1 | Final word of the burst |
| tx_dest | output | 8 | Destination node of the burst |
| rx_valid | input | 1 | Incoming word valid |
| rx_ready | output | 1 | Engine accepts incoming word |
| rx_data | input | 32 | Incoming word |
| rx_last | input | 1 | Final word of the incoming message |

## Verification
The checker watches the rules that hold on every cycle. It checks that the transmit stream is held steady under back-pressure and that no fetch or transmit happens while idle. It also checks that busy only drops after an accepted final word, that receive ready stays low while a staged message waits with no receive posted, that memory is written only toward a posted receive, and that done never rises while posted is still set. The directed scenarios show what only a full exchange can show. These are burst order and word contents, the rejection of bad counts and of a start while busy, the choice between a direct write and staging, the exact drain timing, and the way a second post is ignored.

// File: rtl/msg_dma_pkg.sv
package msg_dma_pkg;
  localparam logic [7:0] OFF_SRC   = 8'h00;
  localparam logic [7:0] OFF_DST   = 8'h04;
  localparam logic [7:0] OFF_LEN   = 8'h08;
  localparam logic [7:0] OFF_CTRL  = 8'h0C;
  localparam logic [7:0] OFF_POST  = 8'h10;
  localparam logic [7:0] OFF_RSTAT = 8'h14;

  typedef enum logic [1:0] {TX_IDLE, TX_READ, TX_WAIT, TX_SEND} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_DIRECT, RX_STAGE, RX_DRAIN} rx_state_e;
endpackage

// File: rtl/msg_dma_regs.sv
module msg_dma_regs
  import msg_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NODE_W    = 8,
  parameter int MAX_WORDS = 16,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              busy,
  input  logic              post_valid,
  input  logic              post_done,
  input  logic              staged,
  output logic [AW-1:0]     src_addr,
  output logic [NODE_W-1:0] dst_node,
  output logic [LEN_W-1:0]  burst_len,
  output logic              start,
  output logic              post_wr,
  output logic [AW-1:0]     post_data
);
  logic len_ok;

  assign len_ok    = (burst_len != '0) && (burst_len <= LEN_W'(MAX_WORDS));
  assign start     = cfg_we && (cfg_addr == OFF_CTRL) && cfg_wdata[0] && !busy && len_ok;
  assign post_wr   = cfg_we && (cfg_addr == OFF_POST);
  assign post_data = cfg_wdata[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_addr  <= '0;
      dst_node  <= '0;
      burst_len <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFF_SRC: src_addr  <= cfg_wdata[AW-1:0];
        OFF_DST: dst_node  <= cfg_wdata[NODE_W-1:0];
        OFF_LEN: burst_len <= cfg_wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFF_SRC:   cfg_rdata = DW'(src_addr);
      OFF_DST:   cfg_rdata = DW'(dst_node);
      OFF_LEN:   cfg_rdata = DW'(burst_len);
      OFF_CTRL:  cfg_rdata = DW'({busy, 1'b0});
      OFF_RSTAT: cfg_rdata = DW'({staged, post_done, post_valid});
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msg_dma_tx.sv
module msg_dma_tx
  import msg_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NODE_W    = 8,
  parameter int MAX_WORDS = 16,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     src_addr,
  input  logic [NODE_W-1:0] dst_node,
  input  logic [LEN_W-1:0]  burst_len,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_last,
  output logic [NODE_W-1:0] tx_dest
);
  tx_state_e         state;
  logic [AW-1:0]     src_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  cnt;
  logic [NODE_W-1:0] dest_q;
  logic [DW-1:0]     hold;
  logic              at_end;

  assign at_end = (cnt == len_q - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TX_IDLE;
      src_q  <= '0;
      len_q  <= '0;
      cnt    <= '0;
      dest_q <= '0;
      hold   <= '0;
    end else begin
      case (state)
        TX_IDLE: if (start) begin
          src_q  <= src_addr;
          len_q  <= burst_len;
          dest_q <= dst_node;
          cnt    <= '0;
          state  <= TX_READ;
        end
        TX_READ: state <= TX_WAIT;
        TX_WAIT: begin
          hold  <= mem_rd_data;
          state <= TX_SEND;
        end
        TX_SEND: if (tx_ready) begin
          if (at_end) begin
            state <= TX_IDLE;
          end else begin
            cnt   <= cnt + LEN_W'(1);
            state <= TX_READ;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign busy        = (state != TX_IDLE);
  assign mem_rd_en   = (state == TX_READ);
  assign mem_rd_addr = src_q + AW'(cnt);
  assign tx_valid    = (state == TX_SEND);
  assign tx_data     = hold;
  assign tx_last     = (state == TX_SEND) && at_end;
  assign tx_dest     = dest_q;
endmodule

// File: rtl/msg_dma_rx.sv
module msg_dma_rx
  import msg_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int MAX_WORDS = 16,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1),
  localparam int IDX_W    = $clog2(MAX_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_wr,
  input  logic [AW-1:0] post_data,
  output logic          post_valid,
  output logic          post_done,
  output logic          staged,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_last,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data
);
  rx_state_e        state;
  logic [AW-1:0]    post_addr;
  logic [LEN_W-1:0] wcnt;
  logic [LEN_W-1:0] buf_len;
  logic [DW-1:0]    buf_mem [MAX_WORDS];
  logic             rx_hs;
  logic             room;
  logic             drain_end;

  assign rx_hs     = rx_valid && rx_ready;
  assign room      = (wcnt < LEN_W'(MAX_WORDS));
  assign drain_end = (wcnt == buf_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      post_addr  <= '0;
      post_valid <= 1'b0;
      post_done  <= 1'b0;
      staged     <= 1'b0;
      wcnt       <= '0;
      buf_len    <= '0;
    end else begin
      if (post_wr && !post_valid) begin
        post_valid <= 1'b1;
        post_addr  <= post_data;
        post_done  <= 1'b0;
      end
      case (state)
        RX_IDLE: begin
          wcnt <= '0;
          if (staged && post_valid) state <= RX_DRAIN;
          else if (rx_valid && !staged) state <= post_valid ? RX_DIRECT : RX_STAGE;
        end
        RX_DIRECT: if (rx_hs) begin
          wcnt <= wcnt + LEN_W'(1);
          if (rx_last) begin
            post_valid <= 1'b0;
            post_done  <= 1'b1;
            state      <= RX_IDLE;
          end
        end
        RX_STAGE: if (rx_hs) begin
          if (room) wcnt <= wcnt + LEN_W'(1);
          if (rx_last) begin
            staged  <= 1'b1;
            buf_len <= room ? wcnt + LEN_W'(1) : wcnt;
            state   <= RX_IDLE;
          end
        end
        RX_DRAIN: begin
          wcnt <= wcnt + LEN_W'(1);
          if (drain_end) begin
            staged     <= 1'b0;
            post_valid <= 1'b0;
            post_done  <= 1'b1;
            state      <= RX_IDLE;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == RX_STAGE && rx_hs && room) buf_mem[wcnt[IDX_W-1:0]] <= rx_data;
  end

  always_comb begin
    rx_ready    = (state == RX_DIRECT) || (state == RX_STAGE);
    mem_wr_en   = 1'b0;
    mem_wr_addr = post_addr + AW'(wcnt);
    mem_wr_data = rx_data;
    if (state == RX_DIRECT) begin
      mem_wr_en = rx_valid;
    end else if (state == RX_DRAIN) begin
      mem_wr_en   = 1'b1;
      mem_wr_data = buf_mem[wcnt[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/msg_dma_engine.sv
module msg_dma_engine
  import msg_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int NODE_W    = 8,
  parameter int MAX_WORDS = 16,
  localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              mem_wr_en,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DW-1:0]     tx_data,
  output logic              tx_last,
  output logic [NODE_W-1:0] tx_dest,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_last
);
  logic              busy;
  logic              start;
  logic              post_wr;
  logic              post_valid;
  logic              post_done;
  logic              staged;
  logic [AW-1:0]     post_data;
  logic [AW-1:0]     src_addr;
  logic [NODE_W-1:0] dst_node;
  logic [LEN_W-1:0]  burst_len;

  msg_dma_regs #(.AW(AW), .DW(DW), .NODE_W(NODE_W), .MAX_WORDS(MAX_WORDS)) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .post_valid(post_valid), .post_done(post_done), .staged(staged),
    .src_addr(src_addr), .dst_node(dst_node), .burst_len(burst_len),
    .start(start), .post_wr(post_wr), .post_data(post_data)
  );

  msg_dma_tx #(.AW(AW), .DW(DW), .NODE_W(NODE_W), .MAX_WORDS(MAX_WORDS)) i_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_node(dst_node), .burst_len(burst_len), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_dest(tx_dest)
  );

  msg_dma_rx #(.AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS)) i_rx (
    .clk(clk), .rst_n(rst_n), .post_wr(post_wr), .post_data(post_data),
    .post_valid(post_valid), .post_done(post_done), .staged(staged),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_last(rx_last), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );
endmodule

// File: rtl/msg_dma_checker.sv
module msg_dma_checker #(
  parameter int DW     = 32,
  parameter int NODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DW-1:0]     tx_data,
  input logic              tx_last,
  input logic [NODE_W-1:0] tx_dest,
  input logic              rx_ready,
  input logic              post_valid,
  input logic              post_done,
  input logic              staged
);
  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_dest));

  // R5: nothing is fetched or sent while idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_valid && !mem_rd_en);

  a_r3_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_valid && tx_ready && tx_last));

  a_r9_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    staged && !post_valid |-> !rx_ready);

  a_r11_write_needs_post: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> post_valid);

  // R7 and R8: completion always retires the posted receive
  a_r7_done_clears_post: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(post_done) |-> !post_valid);
endmodule

bind msg_dma_engine msg_dma_checker #(.DW(DW), .NODE_W(NODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .tx_dest(tx_dest),
  .rx_ready(rx_ready), .post_valid(post_valid), .post_done(post_done),
  .staged(staged)
);

// File: tb/test_msg_dma_engine.sv
module test_msg_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic        mem_wr_en;
  logic [31:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_data;
  logic        tx_last;
  logic [7:0]  tx_dest;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [31:0] rx_data = '0;
  logic        rx_last = 1'b0;

  int errors = 0;
  int checks = 0;
  int rd_count = 0;
  int cap_n = 0;
  int sink_cyc = 0;
  bit bp_mode = 1'b0;
  logic [31:0] mem [0:255];
  logic [31:0] cap_data [0:63];
  logic        cap_last [0:63];
  logic [7:0]  cap_dest [0:63];

  always #5 clk = ~clk;

  msg_dma_engine i_msg_dma_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_dest(tx_dest),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last)
  );

  // local memory model: one-cycle read latency, write every cycle
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem[mem_rd_addr[7:0]];
      rd_count <= rd_count + 1;
    end
    if (mem_wr_en) mem[mem_wr_addr[7:0]] <= mem_wr_data;
  end

  // transmit sink: ready driven at the falling edge, handshake sampled 2 ns later
  always @(negedge clk) begin
    sink_cyc = sink_cyc + 1;
    tx_ready = bp_mode ? (sink_cyc % 3 != 0) : 1'b1;
    #2;
    if (tx_valid && tx_ready && cap_n < 64) begin
      cap_data[cap_n] = tx_data;
      cap_last[cap_n] = tx_last;
      cap_dest[cap_n] = tx_dest;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic send_msg(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = base + i; rx_last = (i == n - 1);
      #1;
      while (!rx_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 200; k++) begin
      cfg_rd(8'h0C, v);
      if (!v[1]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    cfg_rd(8'h0C, v);
    chk(v == 0, "R1 control after reset", v, 0);
    cfg_rd(8'h14, v);
    chk(v == 0, "R1 receive status after reset", v, 0);
    chk(!tx_valid && !rx_ready, "R1 streams idle after reset", {tx_valid, rx_ready}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    cfg_wr(8'h00, 32'h0000_1234);
    cfg_wr(8'h04, 32'h0000_005A);
    cfg_wr(8'h08, 32'h0000_0007);
    cfg_rd(8'h00, v); chk(v == 32'h1234, "R1 source readback", v, 32'h1234);
    cfg_rd(8'h04, v); chk(v == 32'h5A, "R1 node readback", v, 32'h5A);
    cfg_rd(8'h08, v); chk(v == 7, "R1 count readback", v, 7);
  endtask

  task automatic t_bad_len_and_quiet();
    logic [31:0] v;
    int rd0 = rd_count;
    int cap0 = cap_n;
    cfg_wr(8'h08, 32'd0);
    cfg_wr(8'h0C, 32'h1);
    cfg_wr(8'h08, 32'd17);
    cfg_wr(8'h0C, 32'h1);
    repeat (8) @(negedge clk);
    cfg_rd(8'h0C, v);
    chk(v[1] == 1'b0, "R4 busy after bad count", v, 0);
    chk(rd_count == rd0 && cap_n == cap0, "R4 no traffic after bad count", rd_count - rd0 + cap_n - cap0, 0);
    cfg_wr(8'h00, 32'h20);
    cfg_wr(8'h04, 32'h11);
    cfg_wr(8'h08, 32'd3);
    cfg_wr(8'h0C, 32'h2);
    repeat (8) @(negedge clk);
    chk(rd_count == rd0 && cap_n == cap0, "R5 no traffic from plain writes", rd_count - rd0 + cap_n - cap0, 0);
  endtask

  task automatic t_send();
    logic [31:0] v;
    int cap0;
    for (int i = 0; i < 5; i++) mem[8'h10 + i] = 32'hA000_0000 + i;
    cap0 = cap_n;
    bp_mode = 1'b1;
    cfg_wr(8'h00, 32'h10);
    cfg_wr(8'h04, 32'h2A);
    cfg_wr(8'h08, 32'd5);
    cfg_wr(8'h0C, 32'h1);
    cfg_rd(8'h0C, v);
    chk(v[1] == 1'b1, "R3 busy after start", v, 2);
    cfg_wr(8'h08, 32'd2);
    cfg_wr(8'h0C, 32'h1);
    wait_idle();
    repeat (20) @(negedge clk);
    bp_mode = 1'b0;
    chk(cap_n - cap0 == 5, "R3 start while busy ignored, word count", cap_n - cap0, 5);
    for (int i = 0; i < 5; i++) begin
      chk(cap_data[cap0 + i] == 32'hA000_0000 + i, "R2 burst word", cap_data[cap0 + i], 32'hA000_0000 + i);
      chk(cap_last[cap0 + i] == (i == 4), "R2 last marker", cap_last[cap0 + i], (i == 4));
      chk(cap_dest[cap0 + i] == 8'h2A, "R2 destination node", cap_dest[cap0 + i], 8'h2A);
    end
    cfg_rd(8'h0C, v);
    chk(v[1] == 1'b0, "R3 busy clears after burst", v, 0);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    cfg_wr(8'h10, 32'h40);
    cfg_wr(8'h10, 32'h80);
    cfg_rd(8'h14, v);
    chk(v == 1, "R10 posted after two writes", v, 1);
    send_msg(32'hB000_0000, 2);
    cfg_rd(8'h14, v);
    chk(v == 2, "R7 done and no longer posted", v, 2);
    chk(mem[8'h40] == 32'hB000_0000 && mem[8'h41] == 32'hB000_0001, "R7 direct write",
        mem[8'h41], 32'hB000_0001);
    chk(mem[8'h80] == 32'hFFFF_0080, "R10 second address untouched", mem[8'h80], 32'hFFFF_0080);
  endtask

  task automatic t_staged();
    logic [31:0] v;
    send_msg(32'hC000_0000, 4);
    cfg_rd(8'h14, v);
    chk(v == 32'h6, "R8 staged with nothing posted", v, 32'h6);
    fork
      send_msg(32'hD000_0000, 3);
      begin
        for (int k = 0; k < 4; k++) begin
          @(negedge clk);
          #1 chk(!rx_ready, "R9 held off while staged", rx_ready, 0);
        end
        chk(mem[8'h60] == 32'hFFFF_0060, "R11 no write before post", mem[8'h60], 32'hFFFF_0060);
        cfg_wr(8'h10, 32'h60);
        for (int k = 1; k <= 5; k++) begin
          cfg_rd(8'h14, v);
          if (k == 4) chk(v[1] == 1'b0, "R8 not done after N cycles", v, 0);
          if (k == 5) chk(v[1] == 1'b1, "R8 done after N+1 cycles", v, 2);
        end
      end
    join
    for (int i = 0; i < 4; i++)
      chk(mem[8'h60 + i] == 32'hC000_0000 + i, "R8 drained word", mem[8'h60 + i], 32'hC000_0000 + i);
    cfg_rd(8'h14, v);
    chk(v == 32'h6, "R9 second message staged after wait", v, 32'h6);
    cfg_wr(8'h10, 32'h70);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 3; i++)
      chk(mem[8'h70 + i] == 32'hD000_0000 + i, "R8 second drain word", mem[8'h70 + i], 32'hD000_0000 + i);
    cfg_rd(8'h14, v);
    chk(v == 2, "R8 final status", v, 2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_bad_len_and_quiet();
    t_send();
    t_direct();
    t_staged();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule